// File: doc/BRIEF.md
# Bidirectional Gate Scan Shift Register

This block drives the row-select lines of a display panel. A chain of one-bit stages holds the scan token. A start pulse is taken in at one end on a rising scan-clock edge. Each later rising edge moves it one stage onward, so exactly one gate line is selected at a time. A static direction input picks which end receives the pulse. The same input decides which of the two data pins is the input and which one passes the token on to the next chip of a cascade.

The cascade output shows the last stage in the active direction. It is retimed by a flop clocked on the falling edge, so the next chip can sample it safely on its own rising edge. Three output-off inputs each cover an interleaved third of the gate lines. They blank those lines combinationally and leave the stages untouched. The two data pins are modelled as separate input, output and drive-enable signals. Gate outputs are modelled as logic on (1) and off (0).

Top module: `gate_scan_shifter`

## Requirements
- R1: An active-low synchronous reset clears every stage on the rising edge. It clears the cascade flop on the falling edge. While reset is held, all gate outputs and both data-pin outputs read 0.
- R2: With dir_up=1, pin_a_i is sampled on each rising edge into stage 0 (line G1), and each stage k takes the old value of stage k-1, so the token moves from G1 toward G162.
- R3: With dir_up=0, pin_b_i is sampled on each rising edge into stage STAGES-1 (line G162), and each stage k takes the old value of stage k+1, so the token moves from G162 toward G1.
- R4: With dir_up=1 the outputs are pin_a_en=0 and pin_b_en=1. With dir_up=0 they are pin_a_en=1 and pin_b_en=0. The output of the non-driving pin reads 0.
- R5: The driving data pin carries the last stage in the active direction: stage STAGES-1 when dir_up=1, stage 0 when dir_up=0. It changes only on the falling clock edge, so between a rising edge and the next falling edge it still shows the previous value.
- R6: Gate output i (0-based, line G(i+1)) equals stage i AND NOT gate_off[i mod 3]. Bit 0 of gate_off blanks G1, G4, G7 and so on. Bit 1 blanks G2, G5 and so on. Bit 2 blanks G3, G6 and so on.
- R7: gate_off acts combinationally, with no clock edge. It never alters stage contents, so a blanked token reappears at its correct position once its bit returns to 0.
- R8: Two instances joined first pin_b_o to second pin_a_i, and second pin_a_o to first pin_b_i, form one gap-free scan of 2*STAGES lines in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; shift on rising edge, cascade retime on falling edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_up | input | 1 | Static scan direction: 1 = G1 toward G162, 0 = G162 toward G1 |
| gate_off | input | GROUPS | Per-group output blanking, 1 = force lines off |
| pin_a_i | input | 1 | Data pin A input value (start pulse when dir_up=1) |
| pin_a_o | output | 1 | Data pin A output value (cascade when dir_up=0) |
| pin_a_en | output | 1 | Data pin A drive enable |
| pin_b_i | input | 1 | Data pin B input value (start pulse when dir_up=0) |
| pin_b_o | output | 1 | Data pin B output value (cascade when dir_up=1) |
| pin_b_en | output | 1 | Data pin B drive enable |
| gate_o | output | STAGES | Gate line outputs, bit i is line G(i+1) |

## Verification
The assertions check the following on every edge: the reset clearing, the one-stage shift and input capture in each direction, and the exclusive pin roles. They also check that the cascade output follows the end stage one falling edge later, and that no gate line is ever on without its stage set. Other behaviours can only be shown by the bench scenarios. These are the mapping of the interleaved blanking groups, the return of a blanked token after a combinational change with no clock, and the seamless hand-off between two chained instances. The bench sweeps single and multi-pulse patterns through both directions across the full 324-line chain.

// File: rtl/gate_scan_shifter.sv
module gate_scan_shifter #(
  parameter int STAGES = 162,
  parameter int GROUPS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_up,
  input  logic [GROUPS-1:0] gate_off,
  input  logic              pin_a_i,
  output logic              pin_a_o,
  output logic              pin_a_en,
  input  logic              pin_b_i,
  output logic              pin_b_o,
  output logic              pin_b_en,
  output logic [STAGES-1:0] gate_o
);
  logic [STAGES-1:0] stage_q;
  logic              casc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      stage_q <= '0;
    else if (dir_up) stage_q <= {stage_q[STAGES-2:0], pin_a_i};
    else             stage_q <= {pin_b_i, stage_q[STAGES-1:1]};
  end

  // cascade retimed half a cycle later so the next chip samples a settled value
  always_ff @(negedge clk) begin
    if (!rst_n) casc_q <= 1'b0;
    else        casc_q <= dir_up ? stage_q[STAGES-1] : stage_q[0];
  end

  assign pin_a_en = !dir_up;
  assign pin_b_en = dir_up;
  assign pin_a_o  = casc_q & !dir_up;
  assign pin_b_o  = casc_q & dir_up;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_line
    assign gate_o[gi] = stage_q[gi] & ~gate_off[gi % GROUPS];
  end
endmodule

module gate_scan_shifter_chk #(
  parameter int STAGES = 162
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_up,
  input logic              pin_a_i,
  input logic              pin_a_o,
  input logic              pin_a_en,
  input logic              pin_b_i,
  input logic              pin_b_o,
  input logic              pin_b_en,
  input logic [STAGES-1:0] stage_q,
  input logic [STAGES-1:0] gate_o
);
  logic armed_p;
  logic armed_n;
  always_ff @(posedge clk) armed_p <= rst_n;
  always_ff @(negedge clk) armed_n <= rst_n;

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (stage_q == '0));

  assert_shift_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_p && dir_up) |-> (stage_q == {$past(stage_q[STAGES-2:0]), $past(pin_a_i)}));

  assert_shift_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_p && !dir_up) |-> (stage_q == {$past(pin_b_i), $past(stage_q[STAGES-1:1])}));

  assert_pin_roles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({pin_a_en, pin_b_en}) == 1) && (pin_b_en == dir_up));

  assert_cascade_up_R5: assert property (@(negedge clk) disable iff (!rst_n)
    (armed_n && dir_up && $past(dir_up)) |-> (pin_b_o == $past(stage_q[STAGES-1])));

  assert_cascade_down_R5: assert property (@(negedge clk) disable iff (!rst_n)
    (armed_n && !dir_up && !$past(dir_up)) |-> (pin_a_o == $past(stage_q[0])));

  assert_gate_needs_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_o & ~stage_q) == '0));
endmodule

bind gate_scan_shifter gate_scan_shifter_chk #(.STAGES(STAGES)) chk_i (
  .clk(clk), .rst_n(rst_n), .dir_up(dir_up),
  .pin_a_i(pin_a_i), .pin_a_o(pin_a_o), .pin_a_en(pin_a_en),
  .pin_b_i(pin_b_i), .pin_b_o(pin_b_o), .pin_b_en(pin_b_en),
  .stage_q(stage_q), .gate_o(gate_o)
);

// File: tb/gate_scan_shifter_test.sv
module gate_scan_shifter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 162;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         rst_n, dir_up;
  logic [2:0]   off;
  logic         start_a, start_b;
  logic         fwd, back;
  logic         u_ao, u_aen, u_ben, n_bo, n_aen, n_ben;
  logic [N-1:0] u_gate, n_gate;
  int errors = 0;
  int checks = 0;

  gate_scan_shifter #(.STAGES(N), .GROUPS(3)) uut (
    .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .gate_off(off),
    .pin_a_i(start_a), .pin_a_o(u_ao), .pin_a_en(u_aen),
    .pin_b_i(back), .pin_b_o(fwd), .pin_b_en(u_ben), .gate_o(u_gate));

  gate_scan_shifter #(.STAGES(N), .GROUPS(3)) uut_next (
    .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .gate_off(off),
    .pin_a_i(fwd), .pin_a_o(back), .pin_a_en(n_aen),
    .pin_b_i(start_b), .pin_b_o(n_bo), .pin_b_en(n_ben), .gate_o(n_gate));

  function automatic logic pat(int kind, int t);
    if (t < 1) return 1'b0;
    case (kind)
      0: return t == 1;
      1: return (t % 7 == 1) && (t < 60);
      default: return (t % 3 != 0) && (t < 12);
    endcase
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // expected line vectors after e rising edges, from the start-pulse pattern
  task automatic expect_lines(bit up, int kind, int e, output logic [N-1:0] eu, output logic [N-1:0] en);
    for (int i = 0; i < N; i++) begin
      if (up) begin
        eu[i] = pat(kind, e - i);
        en[i] = pat(kind, e - N - i);
      end else begin
        en[i] = pat(kind, e - (N - 1) + i);
        eu[i] = pat(kind, e - (2*N - 1) + i);
      end
      eu[i] = eu[i] & ~off[i % 3];
      en[i] = en[i] & ~off[i % 3];
    end
  endtask

  task automatic chk_casc(string req, bit up, int kind, int e);
    if (up) begin
      chk1(req, fwd,  pat(kind, e - (N - 1)));
      chk1(req, n_bo, pat(kind, e - (2*N - 1)));
      chk1({req, " idle pin"}, u_ao, 1'b0);
    end else begin
      chk1(req, back, pat(kind, e - (N - 1)));
      chk1(req, u_ao, pat(kind, e - (2*N - 1)));
      chk1({req, " idle pin"}, fwd, 1'b0);
    end
  endtask

  task automatic do_reset(bit up);
    rst_n = 1'b0; dir_up = up; off = 3'b000; start_a = 1'b0; start_b = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 reset lines uut", u_gate, '0);
    chk("R1 reset lines next", n_gate, '0);
    #4;
    chk1("R1 reset cascade a", u_ao, 1'b0);
    chk1("R1 reset cascade b", fwd, 1'b0);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic run(bit up, int kind, int edges, bit sweep);
    logic [N-1:0] eu, en;
    do_reset(up);
    for (int e = 1; e <= edges; e++) begin
      off = sweep ? 3'(e % 8) : 3'b000;
      start_a = up ? pat(kind, e) : 1'b0;
      start_b = up ? 1'b0 : pat(kind, e);
      @(posedge clk);
      #3;
      expect_lines(up, kind, e, eu, en);
      chk(up ? "R2 R6 R8 shift up uut" : "R3 R6 R8 shift down uut", u_gate, eu);
      chk(up ? "R2 R6 R8 shift up next" : "R3 R6 R8 shift down next", n_gate, en);
      chk_casc("R5 cascade held until falling edge", up, kind, e - 1);
      if (e == 1) begin
        chk1("R4 pin a enable", u_aen, !up);
        chk1("R4 pin b enable", u_ben, up);
        chk1("R4 next pin a enable", n_aen, !up);
        chk1("R4 next pin b enable", n_ben, up);
      end
      if (!sweep && (e % 50 == 25)) begin
        off = 3'b111;
        #1;
        chk("R7 async blank uut", u_gate, '0);
        chk("R7 async blank next", n_gate, '0);
        off = 3'b000;
        #3;
      end else begin
        #4;
      end
      expect_lines(up, kind, e, eu, en);
      chk("R7 contents kept uut", u_gate, eu);
      chk("R7 contents kept next", n_gate, en);
      chk_casc("R5 cascade after falling edge", up, kind, e);
      #1;
    end
  endtask

  task automatic mid_reset;
    run(1'b1, 0, N, 1'b0);
    rst_n = 1'b0;
    @(posedge clk);
    #3;
    chk("R1 mid-scan reset uut", u_gate, '0);
    chk("R1 mid-scan reset next", n_gate, '0);
    chk1("R5 cascade kept until falling edge", fwd, 1'b1);
    #4;
    chk1("R1 cascade cleared on falling edge", fwd, 1'b0);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; dir_up = 1'b1; off = 3'b000; start_a = 1'b0; start_b = 1'b0;
    run(1'b1, 0, 2*N + 6, 1'b0);
    run(1'b1, 1, 2*N + 6, 1'b1);
    run(1'b0, 0, 2*N + 6, 1'b0);
    run(1'b0, 2, 2*N + 6, 1'b1);
    run(1'b1, 2, 2*N + 6, 1'b0);
    run(1'b0, 1, 2*N + 6, 1'b0);
    mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule